// File: doc/BRIEF.md
# Transport Stream Byte Output Formatter

This block turns a stream of corrected 204-byte transport packets into a byte-wide parallel transport stream output. Each packet is a 0x47 sync byte, 187 payload bytes and 16 parity bytes. With every byte come a strobe and, on the sync byte, a flag saying whether the packet could not be corrected. The block drives a byte clock, the data byte, a valid strobe, a sync marker and an error marker. Each control output has its own framing mode and polarity.

Every accepted byte takes two core clock cycles on the output. In the first cycle the data and the control levels are launched with the byte clock at its idle level. In the second cycle the byte clock moves to its sampling level. The receiver therefore samples on the edge opposite to the one that changed the data. The block hunts for a 0x47 byte before it drives anything and drops lock when a packet does not start with 0x47. Mode, polarity, edge and bit-order inputs are captured only when a sync byte is accepted, so a packet is never reformatted partway through.

Top module: `ts_out_fmt`

## Requirements
- R1: `byte_vld_i` is never high in two consecutive cycles. An emitted byte accepted at edge k shows its data and control levels after edge k, with `ts_clk_o` at idle level. After edge k+1 `ts_clk_o` is at its sampling level if the clock is enabled for that byte. After edge k+2 it returns to idle.
- R2: With `cfg_clk_data_only_i`=0 the byte clock pulses for all 204 positions. With it set to 1 the clock stays at idle level for positions 188 to 203.
- R3: With `cfg_valid_pulse_i`=0 the valid output is active for positions 0 to 187 and inactive for the parity bytes. With it set to 1 the valid output is active at position 0 only.
- R4: `ts_sync_o` is active for position 0 only. While it is active the data output carries 0x47, bit-reversed when R8 applies.
- R5: `ts_err_o` is active only for packets whose sync byte arrived with `uncorr_i`=1. `cfg_err_mode_i`=0 makes it active over all 204 positions, 1 over positions 0 to 187, and 2 or 3 over position 0 only.
- R6: The active level of valid, sync and error is high, or low when `cfg_valid_inv_i`, `cfg_sync_inv_i` or `cfg_err_inv_i` respectively is 1.
- R7: With `cfg_clk_fall_i`=0 the idle level of `ts_clk_o` is 0 and the sampling edge is rising. With it set to 1 the idle level is 1 and the sampling edge is falling.
- R8: With `cfg_lsb_first_i`=0 input bit i appears on `ts_data_o[i]`. With it set to 1 input bit i appears on `ts_data_o[7-i]`.
- R9: Until a 0x47 byte has been accepted, bytes are discarded. Data stays 0 and valid, sync and error stay at inactive level.
- R10: A byte other than 0x47 at position 0 drops lock. At that edge data becomes 0 and valid, sync and error go inactive, and hunting resumes as in R9.
- R11: All configuration inputs take effect only with an accepted sync byte, and they apply from that byte on. Changes at other times do not alter the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Input byte strobe |
| byte_i | input | 8 | Input byte |
| uncorr_i | input | 1 | Packet uncorrectable flag, read with the sync byte |
| cfg_clk_data_only_i | input | 1 | Byte clock gated off over parity bytes |
| cfg_valid_pulse_i | input | 1 | Valid output marks the sync byte only |
| cfg_err_mode_i | input | 2 | Error window: 0 whole, 1 payload, 2/3 sync |
| cfg_clk_fall_i | input | 1 | Receiver samples on the falling edge |
| cfg_valid_inv_i | input | 1 | Valid output active low |
| cfg_sync_inv_i | input | 1 | Sync output active low |
| cfg_err_inv_i | input | 1 | Error output active low |
| cfg_lsb_first_i | input | 1 | Reverse bit order of the data output |
| ts_clk_o | output | 1 | Output byte clock |
| ts_data_o | output | 8 | Output data byte |
| ts_valid_o | output | 1 | Valid strobe |
| ts_sync_o | output | 1 | Sync marker |
| ts_err_o | output | 1 | Uncorrectable packet marker |

## Verification
The assertions check on every cycle that input bytes are spaced at least two cycles apart, and that the byte clock leaves its idle level for exactly one cycle and only after a launch. They also check that the sync marker appears only with the sync pattern on the data lines and always together with an active valid, and that an unlocked block keeps every marker inactive. The framing windows of clock, valid and error across the 204 positions, and the per-packet capture of configuration, can only be shown by the bench. It does this by comparing whole packets under random and directed settings, including settings changed mid-packet and a packet that breaks sync.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;
  typedef enum logic [1:0] {
    ERR_WHOLE = 2'd0,
    ERR_DATA  = 2'd1,
    ERR_SYNC  = 2'd2
  } err_mode_e;

  typedef struct packed {
    logic       clk_data_only;
    logic       valid_pulse;
    logic [1:0] err_mode;
    logic       clk_fall;
    logic       valid_inv;
    logic       sync_inv;
    logic       err_inv;
    logic       lsb_first;
  } cfg_t;
endpackage

// File: rtl/ts_pkt_track.sv
module ts_pkt_track
  import ts_fmt_pkg::*;
#(
  parameter int W = 8,
  parameter int PKT_LEN = 204,
  parameter logic [W-1:0] SYNC = 8'h47,
  localparam int CW = $clog2(PKT_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [W-1:0]  byte_i,
  input  logic          uncorr_i,
  input  cfg_t          cfg_i,
  output logic          start_o,
  output logic          drop_o,
  output logic          emit_o,
  output logic [CW-1:0] pos_o,
  output logic          lock_o,
  output cfg_t          cfg_q_o,
  output logic          err_q_o
);
  logic          lock_q;
  logic [CW-1:0] pos_q;
  logic          is_sync;

  assign is_sync = (byte_i == SYNC);
  assign start_o = vld_i && is_sync && (!lock_q || pos_q == '0);
  assign drop_o  = vld_i && lock_q && pos_q == '0 && !is_sync;
  assign emit_o  = start_o || (vld_i && lock_q && pos_q != '0);
  assign pos_o   = start_o ? '0 : pos_q;
  assign lock_o  = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      pos_q   <= '0;
      cfg_q_o <= '0;
      err_q_o <= 1'b0;
    end else begin
      if (start_o) begin
        lock_q  <= 1'b1;
        cfg_q_o <= cfg_i;
        err_q_o <= uncorr_i;
      end else if (drop_o) begin
        lock_q  <= 1'b0;
      end
      if (emit_o)
        pos_q <= (pos_o == CW'(PKT_LEN - 1)) ? '0 : pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/ts_sig_gen.sv
module ts_sig_gen
  import ts_fmt_pkg::*;
#(
  parameter int W = 8,
  parameter int PKT_LEN = 204,
  parameter int DATA_LEN = 188,
  localparam int CW = $clog2(PKT_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          emit_i,
  input  logic          drop_i,
  input  logic [CW-1:0] pos_i,
  input  cfg_t          cfg_i,
  input  logic          err_i,
  input  logic [W-1:0]  byte_i,
  output logic [W-1:0]  data_o,
  output logic          valid_o,
  output logic          sync_o,
  output logic          err_o,
  output logic          clk_en_o,
  output logic          launch_o
);
  logic         in_data, first, valid_act, err_win;
  logic [W-1:0] rev;

  always_comb begin
    for (int i = 0; i < W; i++) rev[i] = byte_i[W-1-i];
  end

  assign in_data   = pos_i < CW'(DATA_LEN);
  assign first     = pos_i == '0;
  assign valid_act = cfg_i.valid_pulse ? first : in_data;

  always_comb begin
    case (err_mode_e'(cfg_i.err_mode))
      ERR_WHOLE: err_win = 1'b1;
      ERR_DATA:  err_win = in_data;
      default:   err_win = first;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      valid_o  <= 1'b0;
      sync_o   <= 1'b0;
      err_o    <= 1'b0;
      clk_en_o <= 1'b0;
      launch_o <= 1'b0;
    end else begin
      launch_o <= emit_i;
      if (emit_i) begin
        data_o   <= cfg_i.lsb_first ? rev : byte_i;
        valid_o  <= valid_act ^ cfg_i.valid_inv;
        sync_o   <= first ^ cfg_i.sync_inv;
        err_o    <= (err_i && err_win) ^ cfg_i.err_inv;
        clk_en_o <= !cfg_i.clk_data_only || in_data;
      end else if (drop_i) begin
        data_o   <= '0;
        valid_o  <= cfg_i.valid_inv;
        sync_o   <= cfg_i.sync_inv;
        err_o    <= cfg_i.err_inv;
        clk_en_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ts_clk_gen.sv
module ts_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic en_i,
  input  logic fall_i,
  output logic ts_clk_o
);
  // second half of each byte: move to sampling level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_clk_o <= 1'b0;
    else         ts_clk_o <= (launch_i && en_i) ? ~fall_i : fall_i;
  end
endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
  import ts_fmt_pkg::*;
#(
  parameter int W = 8,
  parameter int PKT_LEN = 204,
  parameter int DATA_LEN = 188,
  parameter logic [W-1:0] SYNC = 8'h47
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byte_vld_i,
  input  logic [W-1:0] byte_i,
  input  logic         uncorr_i,
  input  logic         cfg_clk_data_only_i,
  input  logic         cfg_valid_pulse_i,
  input  logic [1:0]   cfg_err_mode_i,
  input  logic         cfg_clk_fall_i,
  input  logic         cfg_valid_inv_i,
  input  logic         cfg_sync_inv_i,
  input  logic         cfg_err_inv_i,
  input  logic         cfg_lsb_first_i,
  output logic         ts_clk_o,
  output logic [W-1:0] ts_data_o,
  output logic         ts_valid_o,
  output logic         ts_sync_o,
  output logic         ts_err_o
);
  localparam int CW = $clog2(PKT_LEN);

  cfg_t          cfg_in, cfg_q, cfg_eff;
  logic          start, drop, emit, lock, err_q, err_eff, clk_en, launch;
  logic [CW-1:0] pos;

  assign cfg_in = {cfg_clk_data_only_i, cfg_valid_pulse_i, cfg_err_mode_i, cfg_clk_fall_i,
                   cfg_valid_inv_i, cfg_sync_inv_i, cfg_err_inv_i, cfg_lsb_first_i};
  // new settings apply from the sync byte that captures them
  assign cfg_eff = start ? cfg_in : cfg_q;
  assign err_eff = start ? uncorr_i : err_q;

  ts_pkt_track #(.W(W), .PKT_LEN(PKT_LEN), .SYNC(SYNC)) u_trk (
    .clk_i, .rst_ni, .vld_i(byte_vld_i), .byte_i, .uncorr_i, .cfg_i(cfg_in),
    .start_o(start), .drop_o(drop), .emit_o(emit), .pos_o(pos), .lock_o(lock),
    .cfg_q_o(cfg_q), .err_q_o(err_q)
  );

  ts_sig_gen #(.W(W), .PKT_LEN(PKT_LEN), .DATA_LEN(DATA_LEN)) u_sig (
    .clk_i, .rst_ni, .emit_i(emit), .drop_i(drop), .pos_i(pos), .cfg_i(cfg_eff),
    .err_i(err_eff), .byte_i, .data_o(ts_data_o), .valid_o(ts_valid_o),
    .sync_o(ts_sync_o), .err_o(ts_err_o), .clk_en_o(clk_en), .launch_o(launch)
  );

  ts_clk_gen u_clk (
    .clk_i, .rst_ni, .launch_i(launch), .en_i(clk_en), .fall_i(cfg_eff.clk_fall),
    .ts_clk_o
  );
endmodule

// File: rtl/ts_fmt_chk.sv
module ts_fmt_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] SYNC = 8'h47
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         byte_vld_i,
  input logic         lock_i,
  input logic         launch_i,
  input logic         clk_fall_i,
  input logic         valid_inv_i,
  input logic         sync_inv_i,
  input logic         err_inv_i,
  input logic         ts_clk_i,
  input logic [W-1:0] ts_data_i,
  input logic         ts_valid_i,
  input logic         ts_sync_i,
  input logic         ts_err_i
);
  logic [W-1:0] sync_rev;
  always_comb begin
    for (int i = 0; i < W; i++) sync_rev[i] = SYNC[W-1-i];
  end

  p_vld_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> !byte_vld_i);

  p_clk_after_launch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_clk_i != clk_fall_i) |-> $past(launch_i));

  p_clk_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_clk_i != clk_fall_i) |=> (ts_clk_i == clk_fall_i));

  p_sync_pattern_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_sync_i != sync_inv_i) |-> (ts_data_i == SYNC || ts_data_i == sync_rev));

  p_sync_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_sync_i != sync_inv_i) |-> (ts_valid_i != valid_inv_i));

  p_quiet_unlocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |-> (ts_valid_i == valid_inv_i && ts_sync_i == sync_inv_i &&
                 ts_err_i == err_inv_i));
endmodule

bind ts_out_fmt ts_fmt_chk #(.W(W), .SYNC(SYNC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .lock_i(lock),
  .launch_i(launch), .clk_fall_i(cfg_q.clk_fall), .valid_inv_i(cfg_q.valid_inv),
  .sync_inv_i(cfg_q.sync_inv), .err_inv_i(cfg_q.err_inv), .ts_clk_i(ts_clk_o),
  .ts_data_i(ts_data_o), .ts_valid_i(ts_valid_o), .ts_sync_i(ts_sync_o),
  .ts_err_i(ts_err_o)
);

// File: tb/sim_ts_out_fmt.sv
`timescale 1ns/1ps
module sim_ts_out_fmt;
  import ts_fmt_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, uncorr = 1'b0;
  logic [7:0] din = '0;
  cfg_t cfg = '0;
  logic ts_clk, ts_valid, ts_sync, ts_err;
  logic [7:0] ts_data;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ts_out_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .byte_i(din), .uncorr_i(uncorr),
    .cfg_clk_data_only_i(cfg.clk_data_only), .cfg_valid_pulse_i(cfg.valid_pulse),
    .cfg_err_mode_i(cfg.err_mode), .cfg_clk_fall_i(cfg.clk_fall),
    .cfg_valid_inv_i(cfg.valid_inv), .cfg_sync_inv_i(cfg.sync_inv),
    .cfg_err_inv_i(cfg.err_inv), .cfg_lsb_first_i(cfg.lsb_first),
    .ts_clk_o(ts_clk), .ts_data_o(ts_data), .ts_valid_o(ts_valid),
    .ts_sync_o(ts_sync), .ts_err_o(ts_err)
  );

  // reference state
  bit   m_lock = 0, m_err = 0, mid_changed = 0;
  int   m_pos = 0;
  cfg_t m_cfg = '0;
  logic [7:0] e_data = '0;
  logic e_valid = 0, e_sync = 0, e_err = 0, e_clken = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  function automatic cfg_t rnd_cfg();
    return cfg_t'($urandom_range(0, 511));
  endfunction

  // caller is positioned just after a negedge
  task automatic send(logic [7:0] b, bit e, int gap);
    bit emit = 0;
    string ctx = "";
    din = b; uncorr = e; vld = 1'b1;
    if (b == 8'h47 && (!m_lock || m_pos == 0)) begin
      m_cfg = cfg; m_err = e; m_lock = 1; m_pos = 0; emit = 1; mid_changed = 0;
    end else if (m_lock && m_pos == 0) begin
      m_lock = 0; ctx = "R10";
      e_data = 0; e_valid = m_cfg.valid_inv; e_sync = m_cfg.sync_inv;
      e_err = m_cfg.err_inv; e_clken = 0;
    end else if (m_lock) begin
      emit = 1;
    end else begin
      ctx = "R9";
    end
    if (emit) begin
      bit ind = m_pos < 188, fst = m_pos == 0, win;
      win = (m_cfg.err_mode == 2'd0) ? 1'b1 : (m_cfg.err_mode == 2'd1) ? ind : fst;
      e_data  = m_cfg.lsb_first ? rev8(b) : b;
      e_valid = (m_cfg.valid_pulse ? fst : ind) ^ m_cfg.valid_inv;
      e_sync  = fst ^ m_cfg.sync_inv;
      e_err   = (m_err && win) ^ m_cfg.err_inv;
      e_clken = !m_cfg.clk_data_only || ind;
      m_pos   = (m_pos == 203) ? 0 : m_pos + 1;
    end
    @(negedge clk);
    vld = 1'b0;
    chk(ctx != "" ? ctx : "R8", "data", ts_data, e_data);
    chk(ctx != "" ? ctx : (mid_changed ? "R11" : "R3"), "valid", {7'd0, ts_valid}, {7'd0, e_valid});
    chk(ctx != "" ? ctx : (m_cfg.sync_inv ? "R6" : "R4"), "sync", {7'd0, ts_sync}, {7'd0, e_sync});
    chk(ctx != "" ? ctx : "R5", "err", {7'd0, ts_err}, {7'd0, e_err});
    chk("R7", "clk_launch", {7'd0, ts_clk}, {7'd0, m_cfg.clk_fall});
    @(negedge clk);
    chk((emit && e_clken) ? "R1" : "R2", "clk_sample", {7'd0, ts_clk},
        {7'd0, (emit && e_clken) ? ~m_cfg.clk_fall : m_cfg.clk_fall});
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R1", "clk_gap", {7'd0, ts_clk}, {7'd0, m_cfg.clk_fall});
    end
  endtask

  task automatic send_pkt(bit e, bit mid_cfg, bit gaps);
    int chg = $urandom_range(1, 203);
    for (int p = 0; p < 204; p++) begin
      if (mid_cfg && p == chg) begin cfg = rnd_cfg(); mid_changed = 1; end
      send(p == 0 ? 8'h47 : 8'($urandom_range(0, 255)), e,
           gaps ? (($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 2)) : 0) : 0);
    end
  endtask

  task automatic garbage(int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom_range(0, 255));
      if (b == 8'h47) b = 8'h46;
      send(b, 1'b1, 0);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "rst_data", ts_data, 8'h00);
    chk("R9", "rst_ctrl", {4'd0, ts_clk, ts_valid, ts_sync, ts_err}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    cfg = rnd_cfg();
    garbage(6);
    // directed: default settings, clean packet
    cfg = '0;
    send_pkt(1'b0, 1'b0, 1'b0);
    // directed: everything inverted / alternate, flagged packet, payload error window
    cfg = '{clk_data_only: 1'b1, valid_pulse: 1'b1, err_mode: 2'd1, clk_fall: 1'b1,
            valid_inv: 1'b1, sync_inv: 1'b1, err_inv: 1'b1, lsb_first: 1'b1};
    send_pkt(1'b1, 1'b0, 1'b0);
    // directed: whole-packet error window, then sync-only window
    cfg = '0; cfg.err_mode = 2'd0;
    send_pkt(1'b1, 1'b1, 1'b0);
    cfg = '0; cfg.err_mode = 2'd3;
    send_pkt(1'b1, 1'b0, 1'b1);
    // random packets
    for (int k = 0; k < 16; k++) begin
      cfg = rnd_cfg();
      send_pkt(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
    end
    // R10: broken sync, hunt, relock
    send(8'h00, 1'b0, 0);
    garbage(5);
    for (int k = 0; k < 3; k++) begin
      cfg = rnd_cfg();
      send_pkt(1'($urandom_range(0, 1)), 1'b1, 1'b1);
    end
    finish_run();
  end
endmodule